// File: doc/BRIEF.md
# Multi-Mode Interrupt Input Qualifier

This block sits between a group of external interrupt request lines and a processor. Each request line passes through a two-flop synchronizer. A per-source detector then qualifies it in one of three ways. In level mode the line is sensed as a held condition. In edge mode an event is taken when a pulse ends. In hybrid mode a leading edge is accepted only if the line stays active for a programmed number of cycles. Edge and hybrid events land in a sticky status bit, so an event that arrives while its source is masked is still there when the source is unmasked. Software clears a sticky bit by writing 1 to it. A single registered interrupt output tells the processor that at least one enabled source is pending.

The per-source detector is a four-state machine:

- **IDLE**: the line is inactive, or the source is in level or off mode.
- **ARMED**: edge mode. The line has gone active and the detector is waiting for it to return.
- **QUALIFY**: hybrid mode. The line has gone active and the detector is counting the cycles it stays active.
- **HOLD**: hybrid mode. The decision has been made and the detector is waiting for the line to go inactive.

The transitions are:

- IDLE→ARMED when the line goes active in edge mode.
- ARMED→IDLE when the line returns to inactive. This transition raises the event.
- IDLE→QUALIFY when the line goes active in hybrid mode with a non-zero count.
- IDLE→HOLD when the line goes active in hybrid mode with a count of zero. This transition raises the event.
- QUALIFY→HOLD when the count is reached. This transition raises the event.
- QUALIFY→IDLE when the line drops before the count is reached. The event is rejected as spurious.
- HOLD→IDLE when the line is released.
- Any state→IDLE when the source's mode no longer matches the state.

Top module: `irq_qualifier`

## Requirements
- R1: In level mode (mode code 00), the pending bit of a source is 1 exactly while its synchronized line is at the active level. It returns to 0 when the line goes inactive. A write of 1 to that status bit has no effect on it.
- R2: In level mode, a pulse that rises and falls between two rising clock edges never makes the source pending.
- R3: In edge mode (mode code 01), the pending bit stays 0 while the line is held active. It becomes 1 only after the line returns to its inactive level (the trailing edge).
- R4: A sticky edge or hybrid pending bit stays set while its enable bit is 0. Enabling the source afterwards raises the interrupt output.
- R5: Several events from one source before a clear merge into one pending bit, and a single clear removes it.
- R6: Writing the status register (address 4) clears only the bits written as 1. An event arriving in the same cycle as the clear of its bit leaves the bit set.
- R7: In hybrid mode (mode code 10) with qualification count Q > 0, the source becomes pending if the line stays active for Q further cycles after its leading edge is sampled. The bit stays set after the line is released.
- R8: In hybrid mode, a line that drops before the qualification count is reached leaves the source not pending.
- R9: In hybrid mode with Q = 0, the source becomes pending on the leading edge, while the line is still active.
- R10: The polarity register (address 1) has one bit per source at bit i. Writing 1 makes the source active-low, so its trailing edge is the low-to-high transition.
- R11: In off mode (mode code 11) a source is never pending and never drives the interrupt output. This is the reset mode of every source.
- R12: The interrupt output is 0 after reset. In every later cycle it equals the OR over all sources of (pending AND enable) from the previous cycle. The enable register is at address 2, one bit per source at bit i.
- R13: A change on a request line reaches a level-mode pending bit two clock edges after it is applied.
- R14: Register addresses are: 0 mode (2 bits per source at [2i+1:2i]), 1 polarity, 2 enable, 3 qualification count (8 bits), 4 status. Status reads return the pending vector. Every register reads back on `reg_rdata` for the address on `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | N_SRC | Raw asynchronous request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 2*N_SRC | Write data |
| reg_rdata | output | 2*N_SRC | Read data for `reg_addr` |
| irq_out | output | 1 | Registered combined interrupt to the processor |

## Verification
Four properties are checked on every cycle:

- The interrupt output equals the registered OR of the enabled pending bits.
- A sticky edge or hybrid bit holds unless it is cleared or its mode is rewritten.
- An edge-mode bit appears only after a sampled inactive line.
- A hybrid-mode bit appears only while the line is still active.

Some behaviours can only be shown by the bench's scenarios, because they depend on pulse width and timing:

- Glitch rejection.
- The exact synchronizer latency.
- Hybrid acceptance against rejection at a given count.
- The event-wins-over-clear collision.
- Polarity inversion.
- The merging of repeated events.

// File: rtl/irq_qual_pkg.sv
package irq_qual_pkg;

    typedef enum logic [1:0] {
        MD_LEVEL  = 2'b00,
        MD_EDGE   = 2'b01,
        MD_HYBRID = 2'b10,
        MD_OFF    = 2'b11
    } det_mode_e;

    typedef enum logic [1:0] {
        DS_IDLE,
        DS_ARMED,
        DS_QUALIFY,
        DS_HOLD
    } det_state_e;

    localparam int          REG_AW   = 3;
    localparam logic [2:0]  A_MODE   = 3'd0;
    localparam logic [2:0]  A_POL    = 3'd1;
    localparam logic [2:0]  A_EN     = 3'd2;
    localparam logic [2:0]  A_QUAL   = 3'd3;
    localparam logic [2:0]  A_STATUS = 3'd4;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/irq_src_detect.sv
module irq_src_detect
    import irq_qual_pkg::*;
#(
    parameter int QW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  det_mode_e     mode,
    input  logic [QW-1:0] qual,
    output logic          evt
);
    localparam logic [QW-1:0] ONE = {{(QW-1){1'b0}}, 1'b1};

    det_state_e    state_q, state_d;
    logic [QW-1:0] cnt_q, cnt_d;
    logic          is_edge, is_hyb, q_zero, q_done;

    assign is_edge = (mode == MD_EDGE);
    assign is_hyb  = (mode == MD_HYBRID);
    assign q_zero  = (qual == '0);
    assign q_done  = (cnt_q == (qual - ONE));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DS_IDLE: begin
                cnt_d = '0;
                if (is_edge && act)
                    state_d = DS_ARMED;
                else if (is_hyb && act)
                    state_d = q_zero ? DS_HOLD : DS_QUALIFY;
            end
            DS_ARMED: begin
                if (!is_edge || !act)
                    state_d = DS_IDLE;
            end
            DS_QUALIFY: begin
                if (!is_hyb || !act)
                    state_d = DS_IDLE;
                else if (q_done)
                    state_d = DS_HOLD;
                else
                    cnt_d = cnt_q + ONE;
            end
            DS_HOLD: begin
                if (!is_hyb || !act)
                    state_d = DS_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        evt = 1'b0;
        unique case (state_q)
            DS_IDLE:    evt = is_hyb && act && q_zero;
            DS_ARMED:   evt = is_edge && !act;
            DS_QUALIFY: evt = is_hyb && act && q_done;
            DS_HOLD:    evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_qual_pkg::*;
#(
    parameter int N  = 4,
    parameter int QW = 8,
    parameter int DW = 2 * N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [N-1:0]      pending,
    output logic [DW-1:0]     rdata,
    output logic [2*N-1:0]    mode_q,
    output logic [N-1:0]      pol_q,
    output logic [N-1:0]      en_q,
    output logic [QW-1:0]     qual_q,
    output logic [N-1:0]      clr
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '1;
            pol_q  <= '0;
            en_q   <= '0;
            qual_q <= '0;
        end else if (wr) begin
            unique case (addr)
                A_MODE:  mode_q <= wdata[2*N-1:0];
                A_POL:   pol_q  <= wdata[N-1:0];
                A_EN:    en_q   <= wdata[N-1:0];
                A_QUAL:  qual_q <= wdata[QW-1:0];
                default: ;
            endcase
        end
    end

    assign clr = (wr && addr == A_STATUS) ? wdata[N-1:0] : '0;

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_MODE:   rdata[2*N-1:0] = mode_q;
            A_POL:    rdata[N-1:0]   = pol_q;
            A_EN:     rdata[N-1:0]   = en_q;
            A_QUAL:   rdata[QW-1:0]  = qual_q;
            A_STATUS: rdata[N-1:0]   = pending;
            default:  rdata          = '0;
        endcase
    end
endmodule

// File: rtl/irq_qualifier.sv
module irq_qualifier
    import irq_qual_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int QUAL_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SRC-1:0]    irq_in,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [2*N_SRC-1:0]  reg_wdata,
    output logic [2*N_SRC-1:0]  reg_rdata,
    output logic                irq_out
);
    localparam int DW = 2 * N_SRC;

    logic [N_SRC-1:0]   sync_q, act, evt, sticky_q, pending, clr;
    logic [N_SRC-1:0]   pol_q, en_q;
    logic [2*N_SRC-1:0] mode_q;
    logic [QUAL_W-1:0]  qual_q;
    logic               irq_q;

    irq_sync #(.W(N_SRC)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(irq_in), .q(sync_q)
    );

    irq_regs #(.N(N_SRC), .QW(QUAL_W), .DW(DW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .pending(pending), .rdata(reg_rdata),
        .mode_q(mode_q), .pol_q(pol_q), .en_q(en_q), .qual_q(qual_q),
        .clr(clr)
    );

    assign act = sync_q ^ pol_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        det_mode_e md;
        assign md = det_mode_e'(mode_q[2*i +: 2]);

        irq_src_detect #(.QW(QUAL_W)) det_i (
            .clk(clk), .rst_n(rst_n), .act(act[i]), .mode(md),
            .qual(qual_q), .evt(evt[i])
        );

        // sticky bit: an event wins over a clear in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sticky_q[i] <= 1'b0;
            else        sticky_q[i] <= (sticky_q[i] & ~clr[i]) | evt[i];
        end

        always_comb begin
            unique case (md)
                MD_LEVEL:  pending[i] = act[i];
                MD_EDGE,
                MD_HYBRID: pending[i] = sticky_q[i];
                MD_OFF:    pending[i] = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pending & en_q);
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/irq_qualifier_chk.sv
module irq_qualifier_chk #(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           irq_out,
    input logic [N-1:0]   pending,
    input logic [N-1:0]   en,
    input logic [N-1:0]   act,
    input logic [2*N-1:0] mode_vec,
    input logic           reg_wr,
    input logic [2:0]     reg_addr,
    input logic [2*N-1:0] reg_wdata
);
    AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == |($past(pending & en)))); // R12

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            ((mode_vec[2*i +: 2] == 2'b01 || mode_vec[2*i +: 2] == 2'b10) && pending[i]
             && !(reg_wr && ((reg_addr == 3'd4 && reg_wdata[i]) || reg_addr == 3'd0)))
            |=> pending[i]); // R4

        AST_EDGE_TRAILING: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_vec[2*i +: 2] == 2'b01 && $past(mode_vec[2*i +: 2]) == 2'b01
             && $rose(pending[i])) |-> !$past(act[i])); // R3

        AST_HYBRID_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_vec[2*i +: 2] == 2'b10 && $past(mode_vec[2*i +: 2]) == 2'b10
             && $rose(pending[i])) |-> $past(act[i])); // R7
    end
endmodule

bind irq_qualifier irq_qualifier_chk #(.N(N_SRC)) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .pending(pending),
    .en(en_q), .act(act), .mode_vec(mode_q), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/irq_qualifier_tb.sv
module irq_qualifier_tb_top;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   irq_in = '0;
    logic           reg_wr = 1'b0;
    logic [2:0]     reg_addr = '0;
    logic [2*N-1:0] reg_wdata = '0;
    logic [2*N-1:0] reg_rdata;
    logic           irq_out;

    int n_chk = 0;
    int n_fail = 0;
    logic cur_pol = 1'b0;

    always #10 clk = ~clk;

    irq_qualifier #(.N_SRC(N), .QUAL_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    typedef struct packed {
        logic [1:0] md;
        logic       pol;
        logic [7:0] width;
        logic [7:0] q;
        logic       exp_mid;
        logic       exp_end;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'b00, 1'b0, 8'd6,  8'd0,  1'b1, 1'b0},  // R1 level
        '{2'b00, 1'b1, 8'd6,  8'd0,  1'b1, 1'b0},  // R10 level active-low
        '{2'b01, 1'b0, 8'd6,  8'd0,  1'b0, 1'b1},  // R3 edge
        '{2'b01, 1'b1, 8'd6,  8'd0,  1'b0, 1'b1},  // R10 edge active-low
        '{2'b10, 1'b0, 8'd20, 8'd10, 1'b1, 1'b1},  // R7 hybrid accepted
        '{2'b10, 1'b0, 8'd5,  8'd10, 1'b0, 1'b0},  // R8 hybrid rejected
        '{2'b10, 1'b0, 8'd4,  8'd0,  1'b1, 1'b1},  // R9 hybrid Q=0
        '{2'b11, 1'b0, 8'd6,  8'd0,  1'b0, 1'b0}   // R11 off
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [2*N-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [2*N-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cfg(input logic [1:0] md, input logic pol, input logic [7:0] q);
        wr(3'd0, '1);
        cur_pol = pol;
        irq_in[0] = pol;
        wr(3'd1, {{(2*N-1){1'b0}}, pol});
        wr(3'd3, q);
        wr(3'd2, 8'h01);
        repeat (4) @(negedge clk);
        wr(3'd4, 8'h0F);
        wr(3'd0, {6'h3F, md});
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse(input int w);
        irq_in[0] = ~cur_pol;
        repeat (w) @(negedge clk);
        irq_in[0] = cur_pol;
    endtask

    logic [2*N-1:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd4, v); check("R12 reset pending", v, 0);
        check("R12 reset irq_out", irq_out, 0);
        rd(3'd0, v); check("R11 reset mode off", v, 8'hFF);

        foreach (VECS[k]) begin
            cfg(VECS[k].md, VECS[k].pol, VECS[k].q);
            irq_in[0] = ~VECS[k].pol;
            repeat (int'(VECS[k].width)) @(negedge clk);
            rd(3'd4, v);
            check($sformatf("R1/R3/R7-R11 vec%0d mid pending", k), v[0], VECS[k].exp_mid);
            check($sformatf("R12 vec%0d mid irq", k), irq_out, VECS[k].exp_mid);
            irq_in[0] = VECS[k].pol;
            repeat (5) @(negedge clk);
            rd(3'd4, v);
            check($sformatf("R1/R3/R7-R11 vec%0d end pending", k), v[0], VECS[k].exp_end);
            check($sformatf("R12 vec%0d end irq", k), irq_out, VECS[k].exp_end);
        end

        // R13 synchronizer latency
        cfg(2'b00, 1'b0, 8'd0);
        irq_in[0] = 1'b1;
        @(negedge clk); rd(3'd4, v); check("R13 one edge not yet", v[0], 0);
        @(negedge clk); rd(3'd4, v); check("R13 two edges visible", v[0], 1);
        // R1 write-1 has no effect on level
        wr(3'd4, 8'h01);
        rd(3'd4, v); check("R1 level ignores clear", v[0], 1);
        irq_in[0] = 1'b0;
        repeat (3) @(negedge clk);

        // R2 glitch between edges
        begin
            logic seen;
            seen = 1'b0;
            @(posedge clk); #3 irq_in[0] = 1'b1; #5 irq_in[0] = 1'b0;
            repeat (4) begin
                @(negedge clk); rd(3'd4, v);
                if (v[0] || irq_out) seen = 1'b1;
            end
            check("R2 glitch ignored", seen, 0);
        end

        // R4 masked edge event survives
        cfg(2'b01, 1'b0, 8'd0);
        wr(3'd2, 8'h00);
        pulse(3);
        repeat (5) @(negedge clk);
        check("R4 masked irq low", irq_out, 0);
        rd(3'd4, v); check("R4 masked still pending", v[0], 1);
        wr(3'd2, 8'h01);
        @(negedge clk);
        check("R4 R12 unmask raises irq", irq_out, 1);

        // R5 merge
        wr(3'd4, 8'h01);
        pulse(3); repeat (3) @(negedge clk);
        pulse(3); repeat (5) @(negedge clk);
        rd(3'd4, v); check("R5 merged pending", v[0], 1);
        wr(3'd4, 8'h01);
        rd(3'd4, v); check("R5 single clear", v[0], 0);

        // R6 selective clear and event-wins collision
        pulse(3); repeat (5) @(negedge clk);
        wr(3'd4, 8'h0E);
        rd(3'd4, v); check("R6 other bits clear only", v[0], 1);
        irq_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        irq_in[0] = 1'b0;
        repeat (2) @(negedge clk);
        wr(3'd4, 8'h01);
        rd(3'd4, v); check("R6 event wins over clear", v[0], 1);
        wr(3'd4, 8'h01);
        rd(3'd4, v); check("R6 later clear works", v[0], 0);

        // R14 readback
        wr(3'd3, 8'hA5);
        rd(3'd3, v); check("R14 qual readback", v, 8'hA5);
        rd(3'd1, v); check("R14 polarity readback", v, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule